// File: doc/BRIEF.md
# Direct-Mapped Branch Target Buffer

This block predicts the next fetch address for an instruction fetch stage. In every cycle the fetch stage presents its current PC, and the block answers in the same cycle with a predicted next PC. The answer is either a target remembered from an earlier taken control transfer or the sequential address PC+4.

The storage is a direct-mapped table with 2^IDX_W slots. Each slot holds a state, a tag and a target. A slot's state is either `SLOT_EMPTY` or `SLOT_FILLED`, and it moves between them on three named transitions:

- **fill**: a taken update to an empty slot.
- **overwrite**: a taken update to a filled slot. This keeps the slot in `SLOT_FILLED` with new contents.
- **clear**: synchronous reset. This returns every slot to `SLOT_EMPTY`.

Resolved control transfers come back on a separate update port, at most one per cycle. Only taken ones allocate. Ordinary instructions therefore never occupy a slot, and they always fall through to PC+4 without being decoded.

Top module: `btb_predictor`

## Requirements
- R1: After synchronous reset every slot is `SLOT_EMPTY`, so every lookup reports `lk_hit`=0 and predicts `lk_pc`+4.
- R2: The slot index is `pc[IDX_W+1:2]`. The two lowest PC bits take no part in index or tag.
- R3: The tag is `pc[ADDR_W-1:IDX_W+2]`. A lookup hits only when its slot is `SLOT_FILLED` and the stored tag equals the lookup tag. On a hit, `lk_pred` is the stored target.
- R4: On a miss, `lk_pred` is `lk_pc`+4 taken modulo 2^ADDR_W.
- R5: An update with `upd_en`=1 and `upd_taken`=0 changes no slot.
- R6: An update with `upd_en`=1 and `upd_taken`=1 writes the tag of `upd_pc` and the target `upd_next_pc` into the slot indexed by `upd_pc`. Lookups see the write from the next cycle onward, not in the same cycle.
- R7: A taken update to a filled slot replaces its entry. A PC that aliased to that slot with the old tag then misses.
- R8: When `upd_en`=0 the table is unchanged, whatever `upd_taken`, `upd_pc` and `upd_next_pc` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| lk_pc | input | ADDR_W | Current fetch PC |
| lk_pred | output | ADDR_W | Predicted next PC |
| lk_hit | output | 1 | Lookup matched a filled slot |
| upd_en | input | 1 | A resolved control transfer is presented |
| upd_pc | input | ADDR_W | PC of the resolved control transfer |
| upd_next_pc | input | ADDR_W | Correct next PC of that transfer |
| upd_taken | input | 1 | The transfer was taken |

## Verification
The bench builds the block with ADDR_W=8 and IDX_W=3, which gives eight slots and a three-bit tag. With these values every one of the 256 lookup addresses can be swept after each phase, including unaligned ones and the address that wraps to zero. Each sweep compares the block against a slot model that the bench computes arithmetically from the index and tag fields. The small tag space also makes aliasing and overwriting easy to provoke, as does the same-cycle write/read case.

// File: rtl/btb_pkg.sv
package btb_pkg;

    typedef enum logic {
        SLOT_EMPTY  = 1'b0,
        SLOT_FILLED = 1'b1
    } slot_state_t;

endpackage

// File: rtl/btb_pc_split.sv
module btb_pc_split #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 7,
    localparam int TAG_W = ADDR_W - IDX_W - 2
) (
    input  logic [ADDR_W-1:0] pc,
    output logic [IDX_W-1:0]  idx,
    output logic [TAG_W-1:0]  tag
);

    // R2: drop the word-offset bits; R3: tag is everything above the index
    always_comb begin
        idx = pc[IDX_W+1:2];
        tag = pc[ADDR_W-1:IDX_W+2];
    end

endmodule

// File: rtl/btb_table.sv
module btb_table
    import btb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 7,
    localparam int TAG_W   = ADDR_W - IDX_W - 2,
    localparam int ENTRIES = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IDX_W-1:0]  w_idx,
    input  logic [TAG_W-1:0]  w_tag,
    input  logic [ADDR_W-1:0] w_tgt,
    input  logic [IDX_W-1:0]  r_idx,
    output logic              r_valid,
    output logic [TAG_W-1:0]  r_tag,
    output logic [ADDR_W-1:0] r_tgt
);

    logic [ENTRIES-1:0] valid_vec;
    logic [TAG_W-1:0]   tag_arr [ENTRIES];
    logic [ADDR_W-1:0]  tgt_arr [ENTRIES];

    genvar g;
    generate
        for (g = 0; g < ENTRIES; g++) begin : g_slot
            slot_state_t st_q;
            slot_state_t st_d;
            logic        sel;

            assign sel = we && (w_idx == IDX_W'(g));

            always_comb begin
                st_d = st_q;
                unique case (st_q)
                    SLOT_EMPTY:  if (sel) st_d = SLOT_FILLED;  // fill
                    SLOT_FILLED: st_d = SLOT_FILLED;           // overwrite keeps it filled
                    default:     st_d = SLOT_EMPTY;
                endcase
            end

            always_ff @(posedge clk) begin
                if (rst) st_q <= SLOT_EMPTY;                   // clear
                else     st_q <= st_d;
            end

            assign valid_vec[g] = (st_q == SLOT_FILLED);
        end
    endgenerate

    // tag and target arrays carry no reset
    always_ff @(posedge clk) begin
        if (we) begin
            tag_arr[w_idx] <= w_tag;
            tgt_arr[w_idx] <= w_tgt;
        end
    end

    always_comb begin
        r_valid = valid_vec[r_idx];
        r_tag   = tag_arr[r_idx];
        r_tgt   = tgt_arr[r_idx];
    end

    // R1: reset leaves every slot empty
    p_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (valid_vec == '0));

    // R6: a write leaves its slot filled on the next cycle
    p_fill_r6: assert property (@(posedge clk) disable iff (rst)
        we |=> valid_vec[$past(w_idx)]);

    // R5 / R8: no write, no change of slot states
    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(valid_vec));

endmodule

// File: rtl/btb_match.sv
module btb_match #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 7,
    localparam int TAG_W = ADDR_W - IDX_W - 2
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic [TAG_W-1:0]  pc_tag,
    input  logic              slot_valid,
    input  logic [TAG_W-1:0]  slot_tag,
    input  logic [ADDR_W-1:0] slot_tgt,
    output logic              hit,
    output logic [ADDR_W-1:0] pred
);

    always_comb begin
        hit  = slot_valid && (slot_tag == pc_tag);   // R3
        pred = hit ? slot_tgt : pc + ADDR_W'(4);     // R4
    end

endmodule

// File: rtl/btb_predictor.sv
module btb_predictor #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 7,
    localparam int TAG_W = ADDR_W - IDX_W - 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] lk_pc,
    output logic [ADDR_W-1:0] lk_pred,
    output logic              lk_hit,
    input  logic              upd_en,
    input  logic [ADDR_W-1:0] upd_pc,
    input  logic [ADDR_W-1:0] upd_next_pc,
    input  logic              upd_taken
);

    logic [IDX_W-1:0]  lk_idx, up_idx;
    logic [TAG_W-1:0]  lk_tag, up_tag;
    logic              slot_valid;
    logic [TAG_W-1:0]  slot_tag;
    logic [ADDR_W-1:0] slot_tgt;
    logic              wr_en;

    assign wr_en = upd_en && upd_taken;   // R5, R8: only taken transfers allocate

    btb_pc_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_split_lk (
        .pc(lk_pc), .idx(lk_idx), .tag(lk_tag));

    btb_pc_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_split_up (
        .pc(upd_pc), .idx(up_idx), .tag(up_tag));

    btb_table #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_table (
        .clk(clk), .rst(rst), .we(wr_en),
        .w_idx(up_idx), .w_tag(up_tag), .w_tgt(upd_next_pc),
        .r_idx(lk_idx), .r_valid(slot_valid), .r_tag(slot_tag), .r_tgt(slot_tgt));

    btb_match #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_match (
        .pc(lk_pc), .pc_tag(lk_tag), .slot_valid(slot_valid),
        .slot_tag(slot_tag), .slot_tgt(slot_tgt),
        .hit(lk_hit), .pred(lk_pred));

    // R4: a miss falls through to the sequential address
    p_miss_r4: assert property (@(posedge clk) disable iff (rst)
        !lk_hit |-> (lk_pred == lk_pc + ADDR_W'(4)));

    // R3 / R6: the PC just written hits its new target one cycle later
    p_visible_r3: assert property (@(posedge clk) disable iff (rst)
        (upd_en && upd_taken) |=>
            ((lk_pc != $past(upd_pc)) || (lk_hit && lk_pred == $past(upd_next_pc))));

endmodule

// File: tb/btb_predictor_tb.sv
module btb_predictor_tb;

    localparam int AW = 8;
    localparam int IW = 3;
    localparam int NE = 1 << IW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] lk_pc = '0;
    logic [AW-1:0] lk_pred;
    logic          lk_hit;
    logic          upd_en = 1'b0;
    logic [AW-1:0] upd_pc = '0;
    logic [AW-1:0] upd_next_pc = '0;
    logic          upd_taken = 1'b0;

    int checks = 0;
    int errors = 0;

    logic          m_val [NE];
    logic [2:0]    m_tag [NE];
    logic [AW-1:0] m_tgt [NE];

    always #5 clk = ~clk;

    btb_predictor #(.ADDR_W(AW), .IDX_W(IW)) u_dut (
        .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_pred(lk_pred), .lk_hit(lk_hit),
        .upd_en(upd_en), .upd_pc(upd_pc), .upd_next_pc(upd_next_pc),
        .upd_taken(upd_taken));

    task automatic check(input string req, input logic [AW:0] act, input logic [AW:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s pc=%0d actual=%0h expected=%0h", req, lk_pc, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < NE; i++) m_val[i] = 1'b0;
    endtask

    // exhaustive sweep of all lookup addresses, expected from index/tag fields
    task automatic sweep(input string req);
        for (int p = 0; p < 256; p++) begin
            logic [AW-1:0] pc;
            logic [IW-1:0] ix;
            logic          h;
            logic [AW-1:0] ep;
            @(negedge clk);
            pc = AW'(p);
            lk_pc = pc;
            ix = pc[4:2];
            h = m_val[ix] && (m_tag[ix] == pc[7:5]);
            ep = h ? m_tgt[ix] : AW'(p + 4);
            #1;
            check(req, {lk_hit, lk_pred}, {h, ep});
        end
    endtask

    task automatic update(input logic en, input logic [AW-1:0] pc,
                          input logic [AW-1:0] nxt, input logic tk);
        @(negedge clk);
        upd_en = en; upd_pc = pc; upd_next_pc = nxt; upd_taken = tk;
        @(negedge clk);
        upd_en = 1'b0; upd_taken = 1'b0;
        if (en && tk) begin
            m_val[pc[4:2]] = 1'b1;
            m_tag[pc[4:2]] = pc[7:5];
            m_tgt[pc[4:2]] = nxt;
        end
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1, R4: empty table, every address misses (252 wraps to 0)
        sweep("R1");

        // R5: not-taken updates on every slot allocate nothing
        for (int i = 0; i < NE; i++) update(1'b1, AW'(i * 4 + 32), AW'(i * 8), 1'b0);
        sweep("R5");

        // R8: taken but not enabled is ignored
        for (int i = 0; i < NE; i++) update(1'b0, AW'(i * 4), AW'(200), 1'b1);
        sweep("R8");

        // R6: a write is not seen in its own cycle, is seen in the next
        @(negedge clk);
        upd_en = 1'b1; upd_pc = 8'd68; upd_next_pc = 8'd240; upd_taken = 1'b1;
        lk_pc = 8'd68;
        #1;
        check("R6 same cycle", {lk_hit, lk_pred}, {1'b0, 8'd72});
        @(negedge clk);
        upd_en = 1'b0; upd_taken = 1'b0;
        m_val[1] = 1'b1; m_tag[1] = 3'd2; m_tgt[1] = 8'd240;
        #1;
        check("R6 next cycle", {lk_hit, lk_pred}, {1'b1, 8'd240});

        // R2, R3: fill every slot with tag 0, distinct targets
        for (int i = 0; i < NE; i++) update(1'b1, AW'(i * 4), AW'((i * 36 + 100) & 8'hFC), 1'b1);
        sweep("R3");

        // R7: alias into slot 1 with tag 5 (pc 164) replaces the tag 0 entry
        update(1'b1, 8'd164, 8'd12, 1'b1);
        @(negedge clk); lk_pc = 8'd4; #1;
        check("R7 old alias", {lk_hit, lk_pred}, {1'b0, 8'd8});
        sweep("R7");

        // R1: reset mid-run clears every slot
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        model_clear();
        sweep("R1 after reset");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule